// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers sixteen interrupt request lines and turns them into a single interrupt request toward a processor. Along with that request it gives an 8-bit vector that names the highest-priority source that is both enabled and pending. Each line passes through a two-stage synchronizer, so the inputs may be asynchronous. Software sets up each line separately as level-sensitive or edge-sensitive, and picks its active sense. A level request follows the synchronized input. An edge request is held until software releases it, or until the processor acknowledges it as the winning source.

Software reaches the block through a small synchronous register bus. Writes take effect on the clock edge, and reads are combinational from the address. The pending bits can always be read, whatever the enable mask holds, so the block also serves as a polling source. Bit n of every register belongs to source n.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable, mode and sense registers read 0, the pending register reads 0 while all inputs are low, and irq_req is low.
- R2: When several enabled sources are pending, the one with the highest index wins, and irq_vec equals 0x20 plus that index.
- R3: A source whose enable bit (address 0) is 0 never raises irq_req, but its pending bit (address 3) still shows its request.
- R4: A source with mode bit 0 (address 1) is level-sensitive. Its pending bit equals the synchronized input when its sense bit (address 2) is 0, and the inverted input when the sense bit is 1.
- R5: A source with mode bit 1 latches its pending bit on a rising input (sense bit 0) or a falling input (sense bit 1). The bit stays set after the input returns to idle.
- R6: Writing to address 4 clears each latched edge pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R7: Writes to address 4 have no effect on the pending bit of a level-sensitive source.
- R8: While irq_req is high, irq_vec lies in the range 0x20 to 0x2F.
- R9: A one-cycle irq_ack clears the pending bit of the current winner if that winner is edge-sensitive. A level-sensitive winner is left unchanged.
- R10: A change on irq_src is not visible in pending or irq_req after the first rising clock edge. It is visible after the second.
- R11: When an edge arrives in the same cycle as a clear write for that bit, the pending bit stays set.
- R12: Address 3 (pending) is read-only and ignores writes. Address 4 (clear) always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 16 | Asynchronous request lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address: 0 enable, 1 mode, 2 sense, 3 pending, 4 clear |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 8 | Vector of the winning source |
| irq_ack | input | 1 | Acknowledge pulse from the processor |

## Verification
A vector table tries the level path with single requests, with competing requests at both ends of the priority order, with masked sources above enabled ones, with inverted sense, and with empty inputs. These cases separate a wrong priority direction, a mask that is applied too early or too late, and a sense bit that is inverted the wrong way. Directed cases then latch rising and falling edges, clear selected bits while leaving others set, and show that clear writes do nothing to level sources. They also line up a clear write exactly with an arriving edge, count the synchronizer delay edge by edge, and acknowledge an edge winner and a level winner to show that only the edge is consumed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [2:0] {
      RA_ENABLE = 3'd0,
      RA_MODE   = 3'd1,
      RA_SENSE  = 3'd2,
      RA_PEND   = 3'd3,
      RA_CLEAR  = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_pend_cell.sv
module irqc_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic line_sync,
   input  logic edge_mode,
   input  logic act_low,
   input  logic clr,
   output logic pend
);
   logic live, prev_q, latch_q, rise;

   assign live = line_sync ^ act_low;
   assign rise = live & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= live;
         latch_q <= edge_mode & (rise | (latch_q & ~clr));
      end
   end

   assign pend = edge_mode ? latch_q : live;

   p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && latch_q && !clr |=> latch_q);
   p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && clr && !rise |=> !latch_q);
   p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && rise |=> latch_q);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     act,
   output logic             any,
   output logic [IDX_W-1:0] win
);
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int i = 0; i < N; i++) begin
         if (act[i]) begin
            any = 1'b1;
            win = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int N_SRC       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_BASE    = 32,
   parameter int VEC_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_src,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [N_SRC-1:0] bus_wdata,
   output logic [N_SRC-1:0] bus_rdata,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   input  logic             irq_ack
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 1 || N_SRC > 16) begin : g_bad_n
      $error("prio_irq_ctrl: N_SRC must be 1..16");
   end
   if (VEC_BASE + N_SRC > (1 << VEC_W)) begin : g_bad_vec
      $error("prio_irq_ctrl: vector range does not fit VEC_W");
   end

   logic [N_SRC-1:0] en_q, mode_q, sense_q;
   logic [N_SRC-1:0] line_s, pend, act, sw_clr, ack_clr, clr;
   logic [IDX_W-1:0] win;
   logic             wr_en;

   assign wr_en = bus_sel && bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         mode_q  <= '0;
         sense_q <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(bus_addr))
            RA_ENABLE: en_q    <= bus_wdata;
            RA_MODE:   mode_q  <= bus_wdata;
            RA_SENSE:  sense_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr_e'(bus_addr))
         RA_ENABLE: bus_rdata = en_q;
         RA_MODE:   bus_rdata = mode_q;
         RA_SENSE:  bus_rdata = sense_q;
         RA_PEND:   bus_rdata = pend;
         default:   bus_rdata = '0;
      endcase
   end

   irqc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_src), .q(line_s));

   assign sw_clr  = (wr_en && reg_addr_e'(bus_addr) == RA_CLEAR) ? bus_wdata : '0;
   assign ack_clr = (irq_ack && irq_req) ? (N_SRC'(1) << win) : '0;
   assign clr     = sw_clr | ack_clr;

   for (genvar i = 0; i < N_SRC; i++) begin : g_cell
      irqc_pend_cell u_cell (
         .clk(clk), .rst_n(rst_n), .line_sync(line_s[i]),
         .edge_mode(mode_q[i]), .act_low(sense_q[i]),
         .clr(clr[i]), .pend(pend[i]));
   end

   assign act = pend & en_q;

   irqc_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
      .act(act), .any(irq_req), .win(win));

   assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(win);

   p_top_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((act >> win) == N_SRC'(1)));
   p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |-> !irq_req);
   p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec >= VEC_W'(VEC_BASE)) &&
                  (irq_vec <= VEC_W'(VEC_BASE + N_SRC - 1)));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_src = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, irq_ack = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_req;
   logic [7:0]  irq_vec;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_ack(irq_ack));

   typedef struct packed {
      logic [15:0] en;
      logic [15:0] sense;
      logic [15:0] src;
      logic        req;
      logic [7:0]  vec;
   } row_t;

   localparam row_t TBL [8] = '{
      '{16'hFFFF, 16'h0000, 16'h0001, 1'b1, 8'h20},
      '{16'hFFFF, 16'h0000, 16'h8001, 1'b1, 8'h2F},
      '{16'h7FFF, 16'h0000, 16'h8010, 1'b1, 8'h24},
      '{16'h0000, 16'h0000, 16'hFFFF, 1'b0, 8'h00},
      '{16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 8'h20},
      '{16'h00F0, 16'h0000, 16'h0A50, 1'b1, 8'h26},
      '{16'hFFFF, 16'h00FF, 16'h00FF, 1'b0, 8'h00},
      '{16'hFFFF, 16'h0000, 16'h0000, 1'b0, 8'h00}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a; #2; d = bus_rdata;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input logic req, input logic [7:0] vec);
      chk({tag, " req"}, {15'd0, irq_req}, {15'd0, req});
      if (req) chk({tag, " vec"}, {8'd0, irq_vec}, {8'd0, vec});
   endtask

   task automatic pulse(input logic [15:0] m);
      irq_src = irq_src | m; cyc(3);
      irq_src = irq_src & ~m; cyc(3);
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      cyc(3); rst_n = 1'b1; cyc(1);
      // R1 reset state
      rd(0, d); chk("R1 enable", d, 16'h0);
      rd(1, d); chk("R1 mode", d, 16'h0);
      rd(2, d); chk("R1 sense", d, 16'h0);
      rd(3, d); chk("R1 pend", d, 16'h0);
      chk_out("R1", 1'b0, 8'h0);

      // R2 R3 R4 R8 table of level-mode patterns
      for (int k = 0; k < 8; k++) begin
         wr(0, TBL[k].en); wr(2, TBL[k].sense);
         irq_src = TBL[k].src; cyc(4);
         rd(3, d); chk($sformatf("R4 row%0d pend", k), d, TBL[k].src ^ TBL[k].sense);
         chk_out($sformatf("R2 R3 R8 row%0d", k), TBL[k].req, TBL[k].vec);
      end

      // R12 pending read-only, clear reads zero
      wr(3, 16'hFFFF); rd(3, d); chk("R12 pend ro", d, 16'h0);
      wr(4, 16'hFFFF); rd(4, d); chk("R12 clear reads 0", d, 16'h0);

      // R10 synchronizer latency
      irq_src = 16'h0001; cyc(1);
      rd(3, d); chk("R10 after 1 edge", d, 16'h0);
      chk_out("R10 req after 1 edge", 1'b0, 8'h0);
      cyc(1);
      rd(3, d); chk("R10 after 2 edges", d, 16'h0001);
      irq_src = '0; cyc(3);

      // R5 rising edge latch
      wr(1, 16'h0026);
      pulse(16'h0002);
      rd(3, d); chk("R5 rising latched", d, 16'h0002);
      chk_out("R5", 1'b1, 8'h21);
      pulse(16'h0004);
      rd(3, d); chk("R5 second latch", d, 16'h0006);
      chk_out("R2 edge", 1'b1, 8'h22);

      // R6 selective clear, R7 level immune
      wr(4, 16'h0002);
      rd(3, d); chk("R6 w1c selective", d, 16'h0004);
      irq_src = 16'h0200; cyc(3);
      wr(4, 16'h0200);
      rd(3, d); chk("R7 level immune", d, 16'h0204);
      irq_src = '0; cyc(3);
      wr(4, 16'h0004);
      rd(3, d); chk("R6 cleared", d, 16'h0000);

      // R11 edge coincident with clear
      irq_src = 16'h0020;
      @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
      wr(4, 16'h0020);
      rd(3, d); chk("R11 edge beats clear", d, 16'h0020);
      irq_src = '0; cyc(3);
      wr(4, 16'h0020);
      rd(3, d); chk("R11 later clear", d, 16'h0000);

      // R5 falling edge latch
      wr(2, 16'h0002); cyc(1);
      wr(4, 16'h0002);
      irq_src = 16'h0002; cyc(4);
      rd(3, d); chk("R5 no latch on rise when falling", d, 16'h0000);
      irq_src = 16'h0000; cyc(4);
      rd(3, d); chk("R5 falling latched", d, 16'h0002);
      wr(2, 16'h0000); cyc(1);
      wr(4, 16'h0002);
      rd(3, d); chk("R6 clear falling", d, 16'h0000);

      // R9 acknowledge
      pulse(16'h0020);
      irq_src = 16'h0200; cyc(3);
      chk_out("R9 level wins", 1'b1, 8'h29);
      irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
      rd(3, d); chk("R9 level kept", d, 16'h0220);
      irq_src = '0; cyc(3);
      chk_out("R9 edge next", 1'b1, 8'h25);
      irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
      rd(3, d); chk("R9 edge consumed", d, 16'h0000);
      chk_out("R9 idle", 1'b0, 8'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule